// File: doc/BRIEF.md
# Multi-Latency Issue Hazard Scoreboard

This block sits in the issue stage of an in-order core whose three fixed-latency execution pipes share one register-file write port: a short ALU pipe, a two-stage memory pipe and a multiplier whose result reaches the register file four cycles after issue. Since the pipes have different lengths, results are written back and retired out of order. Each cycle the block is shown one candidate instruction (pipe type, destination, two sources) and answers issue or stall. For each source that it allows to issue, it also says whether the operand comes from a bypass and which pipe produces it.

In-flight writes are kept as one shift row per architectural register. A bit's position in the row is the number of cycles left until writeback, and every row moves one step toward zero on each clock. An issued write is not placed at the head of its row. It enters at the slot set by its own pipe latency. A single look at the column for that slot shows whether the write port is already booked in the cycle when the new result would land. Results of variable latency, such as a divide or a load that missed, are tracked by a separate pending flag per register. An external completion strobe clears that flag.

Top module: `issue_scoreboard`

## Requirements
- R1: With `cand_valid` low, `issue` is 0. A valid candidate that has no hazard gets `issue` = 1 in the same cycle. Pipe codes are ALU=0, memory=1, multiplier=2, variable latency=3.
- R2: An issued write whose destination is not register 0 reaches writeback 2 cycles after issue for ALU and memory and 4 cycles after issue for the multiplier. A fixed-latency candidate stalls while an earlier write is booked for the same writeback cycle. It repeats the check each cycle and issues on the first cycle that is free. No two writes ever share a writeback cycle.
- R3: A candidate stalls while its destination has a fixed-latency write in flight or a pending variable-latency result. A register never holds two in-flight writes.
- R4: A source with a write in flight stalls the candidate until the producer can forward. The ALU can forward with 1 cycle left before writeback, the memory pipe and the multiplier only in their writeback cycle. Once forwarding is allowed, `srcN_fwd` is 1 and `srcN_unit` gives the producer's pipe code. Otherwise `srcN_fwd` is 0 and `srcN_unit` is 0.
- R5: Once the producer's writeback cycle has passed, the source reads the register file (`srcN_fwd` = 0) and does not stall.
- R6: Issuing a variable-latency op marks its destination pending without booking the write port. Any reader of a pending register stalls and is given no bypass. This holds in the cycle the completion strobe names that register as well. The reader issues the following cycle.
- R7: A completion strobe clears only the register it names. In one cycle, one register can be set pending by an issue while a different register is cleared.
- R8: Register 0 never becomes busy or pending. Writes to it book nothing, and reading it never stalls.
- R9: Reset clears every in-flight write and every pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cand_valid | input | 1 | Candidate instruction present |
| cand_pipe | input | 2 | Pipe code: 0 ALU, 1 memory, 2 multiplier, 3 variable latency |
| cand_dst | input | REG_W | Destination register (0 = no write) |
| cand_src0 | input | REG_W | First source register |
| cand_src1 | input | REG_W | Second source register |
| done_valid | input | 1 | Variable-latency completion strobe |
| done_reg | input | REG_W | Register whose pending result has completed |
| issue | output | 1 | Candidate issues this cycle |
| src0_fwd | output | 1 | First source is taken from a bypass |
| src0_unit | output | 2 | Pipe code of the first source's producer |
| src1_fwd | output | 1 | Second source is taken from a bypass |
| src1_unit | output | 2 | Pipe code of the second source's producer |

## Verification
Two functions can fall in the same cycle. The first pair is a completion strobe clearing one register while a variable-latency issue marks another, and the bench then shows that a write to the cleared register goes ahead while a read of the newly marked one is still held. The second pair is a completion strobe arriving in the same cycle as a candidate that reads that register: the candidate must stall in that cycle and issue in the next. A third coincidence comes from a multiply placed so that a later ALU op would land on the write port in the same cycle. That ALU op has to stall for exactly one cycle, and the test judges it by the cycle in which issue rises.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Pipe codes seen on the candidate and bypass-unit ports.
    typedef enum logic [1:0] {
        PIPE_ALU = 2'd0,
        PIPE_MEM = 2'd1,
        PIPE_MUL = 2'd2,
        PIPE_VAR = 2'd3
    } pipe_e;

    // Verdict for one source operand.
    typedef struct packed {
        logic  ok;    // source allows issue
        logic  fwd;   // take operand from bypass
        pipe_e unit;  // producing pipe when fwd
    } src_res_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sb_slot_table.sv
module sb_slot_table
    import sb_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int DEPTH  = 4,
    parameter int REG_W  = 5,
    parameter int SLOT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc,
    input  logic [REG_W-1:0]            alloc_reg,
    input  logic [SLOT_W-1:0]           alloc_slot,
    input  pipe_e                       alloc_unit,
    output logic [NREG-1:0][DEPTH-1:0]  busy,
    output pipe_e [NREG-1:0]            unit
);

    // One row per register: bit k set means writeback happens k cycles from now.
    for (genvar r = 0; r < NREG; r++) begin : g_row
        if (r == 0) begin : g_zero
            assign busy[r] = '0;
            assign unit[r] = PIPE_ALU;
        end else begin : g_live
            logic             hit;
            logic [DEPTH-1:0] row_q;
            pipe_e            unit_q;

            assign hit = alloc && (alloc_reg == REG_W'(r));

            always_ff @(posedge clk) begin
                if (rst) begin
                    row_q  <= '0;
                    unit_q <= PIPE_ALU;
                end else begin
                    row_q <= (row_q >> 1) | (hit ? (DEPTH'(1) << alloc_slot) : '0);
                    if (hit) begin
                        unit_q <= alloc_unit;
                    end
                end
            end

            assign busy[r] = row_q;
            assign unit[r] = unit_q;
        end
    end

endmodule

// File: rtl/sb_pending.sv
module sb_pending #(
    parameter int NREG  = 32,
    parameter int REG_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [REG_W-1:0]  set_reg,
    input  logic              clr_en,
    input  logic [REG_W-1:0]  clr_reg,
    output logic [NREG-1:0]   pending
);

    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] clr_mask;
    logic [NREG-1:0] pend_d;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_en) set_mask[set_reg] = 1'b1;
        if (clr_en) clr_mask[clr_reg] = 1'b1;
        set_mask[0] = 1'b0;                 // register 0 is never waited on
        pend_d = (pending & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= pend_d;
    end

endmodule

// File: rtl/sb_src_check.sv
module sb_src_check
    import sb_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int DEPTH   = 4,
    parameter int REG_W   = 5,
    parameter int SLOT_W  = 3,
    parameter int BYP_ALU = 1,
    parameter int BYP_MEM = 0,
    parameter int BYP_MUL = 0
) (
    input  logic [REG_W-1:0]            src,
    input  logic [NREG-1:0][DEPTH-1:0]  busy,
    input  pipe_e [NREG-1:0]            unit,
    input  logic [NREG-1:0]             pending,
    output src_res_t                    res
);

    logic [DEPTH-1:0]  row;
    logic [SLOT_W-1:0] remain;
    logic [SLOT_W-1:0] ready_at;
    pipe_e             prod;

    always_comb begin
        row    = busy[src];
        prod   = unit[src];
        remain = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (row[k]) remain = SLOT_W'(k);
        end
        unique case (prod)
            PIPE_ALU: ready_at = SLOT_W'(BYP_ALU);
            PIPE_MEM: ready_at = SLOT_W'(BYP_MEM);
            PIPE_MUL: ready_at = SLOT_W'(BYP_MUL);
            default:  ready_at = '0;
        endcase

        res = '{ok: 1'b1, fwd: 1'b0, unit: PIPE_ALU};
        if (src != '0) begin
            if (pending[src]) begin
                res.ok = 1'b0;
            end else if (|row) begin
                if (remain <= ready_at) begin
                    res.fwd  = 1'b1;
                    res.unit = prod;
                end else begin
                    res.ok = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int LAT_ALU = 2,
    parameter int LAT_MEM = 2,
    parameter int LAT_MUL = 4,
    parameter int BYP_ALU = 1,
    parameter int BYP_MEM = 0,
    parameter int BYP_MUL = 0,
    localparam int REG_W  = $clog2(NREG),
    localparam int DEPTH  = max_int(LAT_MUL, max_int(LAT_ALU, LAT_MEM)),
    localparam int SLOT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_valid,
    input  logic [1:0]        cand_pipe,
    input  logic [REG_W-1:0]  cand_dst,
    input  logic [REG_W-1:0]  cand_src0,
    input  logic [REG_W-1:0]  cand_src1,
    input  logic              done_valid,
    input  logic [REG_W-1:0]  done_reg,
    output logic              issue,
    output logic              src0_fwd,
    output logic [1:0]        src0_unit,
    output logic              src1_fwd,
    output logic [1:0]        src1_unit
);

    pipe_e                      pipe;
    logic                       has_dst;
    logic [SLOT_W-1:0]          lat;
    logic [NREG-1:0][DEPTH-1:0] busy_q;
    pipe_e [NREG-1:0]           unit_q;
    logic [NREG-1:0]            pend_q;
    logic [DEPTH-1:0]           col_any;
    logic                       port_hit;
    logic                       waw_hit;
    logic                       alloc;
    logic                       var_set;
    logic [REG_W-1:0]           src_reg [2];
    src_res_t                   src_res [2];

    assign pipe    = pipe_e'(cand_pipe);
    assign has_dst = (cand_dst != '0);

    always_comb begin
        unique case (pipe)
            PIPE_ALU: lat = SLOT_W'(LAT_ALU);
            PIPE_MEM: lat = SLOT_W'(LAT_MEM);
            PIPE_MUL: lat = SLOT_W'(LAT_MUL);
            default:  lat = '0;
        endcase
    end

    // Which writeback cycles are already booked, over all registers.
    always_comb begin
        col_any = '0;
        for (int k = 0; k < DEPTH; k++) begin
            for (int r = 0; r < NREG; r++) begin
                col_any[k] = col_any[k] | busy_q[r][k];
            end
        end
    end

    always_comb begin
        port_hit = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (lat == SLOT_W'(k) && col_any[k]) port_hit = 1'b1;
        end
        if (!has_dst || pipe == PIPE_VAR) port_hit = 1'b0;
    end

    assign waw_hit = has_dst && ((|busy_q[cand_dst]) || pend_q[cand_dst]);

    assign src_reg[0] = cand_src0;
    assign src_reg[1] = cand_src1;

    for (genvar i = 0; i < 2; i++) begin : g_src
        sb_src_check #(
            .NREG(NREG), .DEPTH(DEPTH), .REG_W(REG_W), .SLOT_W(SLOT_W),
            .BYP_ALU(BYP_ALU), .BYP_MEM(BYP_MEM), .BYP_MUL(BYP_MUL)
        ) u_src (
            .src     (src_reg[i]),
            .busy    (busy_q),
            .unit    (unit_q),
            .pending (pend_q),
            .res     (src_res[i])
        );
    end

    assign issue = cand_valid && !port_hit && !waw_hit
                   && src_res[0].ok && src_res[1].ok;

    assign alloc   = issue && has_dst && (pipe != PIPE_VAR);
    assign var_set = issue && has_dst && (pipe == PIPE_VAR);

    sb_slot_table #(
        .NREG(NREG), .DEPTH(DEPTH), .REG_W(REG_W), .SLOT_W(SLOT_W)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .alloc      (alloc),
        .alloc_reg  (cand_dst),
        .alloc_slot (lat - SLOT_W'(1)),
        .alloc_unit (pipe),
        .busy       (busy_q),
        .unit       (unit_q)
    );

    sb_pending #(
        .NREG(NREG), .REG_W(REG_W)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (var_set),
        .set_reg (cand_dst),
        .clr_en  (done_valid),
        .clr_reg (done_reg),
        .pending (pend_q)
    );

    assign src0_fwd  = issue && src_res[0].fwd;
    assign src0_unit = src0_fwd ? src_res[0].unit : 2'd0;
    assign src1_fwd  = issue && src_res[1].fwd;
    assign src1_unit = src1_fwd ? src_res[1].unit : 2'd0;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NREG    = 32,
    parameter int REG_W   = 5,
    parameter int DEPTH   = 4,
    parameter int LAT_MUL = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cand_valid,
    input logic [1:0]                  cand_pipe,
    input logic [REG_W-1:0]            cand_dst,
    input logic [REG_W-1:0]            cand_src0,
    input logic                        done_valid,
    input logic [REG_W-1:0]            done_reg,
    input logic                        issue,
    input logic [NREG-1:0][DEPTH-1:0]  busy,
    input logic [NREG-1:0]             pending
);

    logic [DEPTH-1:0][NREG-1:0] col;

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            for (int r = 0; r < NREG; r++) begin
                col[k][r] = busy[r][k];
            end
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_col
        // R2
        port_single_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col[k]));
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // R3
        one_write_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(busy[r]));
    end

    // R2
    mul_entry_chk: assert property (@(posedge clk) disable iff (rst)
        issue && cand_pipe == 2'd2 && cand_dst != '0
        |=> busy[$past(cand_dst)][LAT_MUL-1]);

    // R6
    pend_block_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid && cand_src0 != '0 && pending[cand_src0] |-> !issue);

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid && !(issue && cand_pipe == 2'd3 && cand_dst == done_reg)
        |=> !pending[$past(done_reg)]);

    // R8
    reg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        busy[0] == '0 && !pending[0]);

endmodule

bind issue_scoreboard sb_checker #(
    .NREG(NREG), .REG_W(REG_W), .DEPTH(DEPTH), .LAT_MUL(LAT_MUL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cand_valid (cand_valid),
    .cand_pipe  (cand_pipe),
    .cand_dst   (cand_dst),
    .cand_src0  (cand_src0),
    .done_valid (done_valid),
    .done_reg   (done_reg),
    .issue      (issue),
    .busy       (busy_q),
    .pending    (pend_q)
);

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cand_valid = 1'b0;
    logic [1:0] cand_pipe = 2'd0;
    logic [4:0] cand_dst = '0, cand_src0 = '0, cand_src1 = '0;
    logic       done_valid = 1'b0;
    logic [4:0] done_reg = '0;
    logic       issue, src0_fwd, src1_fwd;
    logic [1:0] src0_unit, src1_unit;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    issue_scoreboard u_dut (
        .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_pipe(cand_pipe),
        .cand_dst(cand_dst), .cand_src0(cand_src0), .cand_src1(cand_src1),
        .done_valid(done_valid), .done_reg(done_reg), .issue(issue),
        .src0_fwd(src0_fwd), .src0_unit(src0_unit),
        .src1_fwd(src1_fwd), .src1_unit(src1_unit)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] p;
        logic [4:0] d;
        logic [4:0] s0;
        logic [4:0] s1;
        logic       dv;
        logic [4:0] dr;
        logic       ei;
        logic       f0;
        logic [1:0] u0;
        logic       f1;
        logic [1:0] u1;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 35;
    // v  pipe dst s0  s1  dv dr  | iss f0 u0 f1 u1 | req
    localparam vec_t VEC [NV] = '{
        '{0, 0,  0,  0,  0, 0,  0,  0, 0, 0, 0, 0, 1}, // R1 idle
        '{1, 2,  1,  2,  3, 0,  0,  1, 0, 0, 0, 0, 1}, // R1 mul r1
        '{1, 0,  4,  1,  0, 0,  0,  0, 0, 0, 0, 0, 4}, // R4 r1 three left
        '{1, 0,  4,  1,  0, 0,  0,  0, 0, 0, 0, 0, 4}, // R4 two left
        '{1, 0,  4,  1,  0, 0,  0,  0, 0, 0, 0, 0, 4}, // R4 one left
        '{1, 0,  4,  1,  0, 0,  0,  1, 1, 2, 0, 0, 4}, // R4 mul bypass
        '{1, 0,  5,  4,  1, 0,  0,  1, 1, 0, 0, 0, 5}, // R5 r1 from file, r4 alu bypass
        '{1, 2,  6,  0,  0, 0,  0,  1, 0, 0, 0, 0, 2}, // R2 mul r6
        '{0, 0,  0,  0,  0, 0,  0,  0, 0, 0, 0, 0, 1}, // R1 idle
        '{1, 0,  7,  0,  0, 0,  0,  0, 0, 0, 0, 0, 2}, // R2 port clash
        '{1, 0,  7,  0,  0, 0,  0,  1, 0, 0, 0, 0, 2}, // R2 retry issues
        '{1, 0,  7,  0,  0, 0,  0,  0, 0, 0, 0, 0, 3}, // R3 waw
        '{1, 0,  7,  0,  0, 0,  0,  0, 0, 0, 0, 0, 3}, // R3 waw writeback cycle
        '{1, 0,  7,  0,  0, 0,  0,  1, 0, 0, 0, 0, 3}, // R3 clear
        '{1, 1,  8,  7,  0, 0,  0,  1, 1, 0, 0, 0, 4}, // R4 alu bypass early
        '{1, 0,  9,  8,  0, 0,  0,  0, 0, 0, 0, 0, 4}, // R4 mem not ready
        '{1, 0,  9,  8,  0, 0,  0,  1, 1, 1, 0, 0, 4}, // R4 mem bypass
        '{1, 3, 10,  9,  0, 0,  0,  1, 1, 0, 0, 0, 6}, // R6 var r10
        '{1, 0, 11, 10,  0, 0,  0,  0, 0, 0, 0, 0, 6}, // R6 reader waits
        '{1, 0, 11, 10,  0, 1, 10,  0, 0, 0, 0, 0, 6}, // R6 strobe cycle still waits
        '{1, 0, 11, 10,  0, 0,  0,  1, 0, 0, 0, 0, 6}, // R6 issues, no bypass
        '{1, 2,  0,  0,  0, 0,  0,  1, 0, 0, 0, 0, 8}, // R8 mul to r0
        '{1, 0, 12,  0,  0, 0,  0,  1, 0, 0, 0, 0, 8}, // R8
        '{1, 0, 13,  0,  0, 0,  0,  1, 0, 0, 0, 0, 8}, // R8 no port booked
        '{1, 3,  0,  0,  0, 0,  0,  1, 0, 0, 0, 0, 8}, // R8 var to r0
        '{1, 0, 14,  0,  0, 0,  0,  1, 0, 0, 0, 0, 8}, // R8
        '{1, 3, 15,  0,  0, 0,  0,  1, 0, 0, 0, 0, 6}, // R6 var r15
        '{1, 2, 15,  0,  0, 0,  0,  0, 0, 0, 0, 0, 3}, // R3 waw on pending
        '{1, 3, 16,  0,  0, 1, 15,  1, 0, 0, 0, 0, 7}, // R7 set r16, clear r15
        '{1, 2, 15,  0,  0, 0,  0,  1, 0, 0, 0, 0, 7}, // R7 r15 free
        '{1, 0, 17, 16,  0, 0,  0,  0, 0, 0, 0, 0, 7}, // R7 r16 still pending
        '{1, 0, 17, 16,  0, 1, 16,  0, 0, 0, 0, 0, 6}, // R6
        '{1, 0, 17, 16,  0, 0,  0,  1, 0, 0, 0, 0, 6}, // R6
        '{1, 0, 18,  0, 17, 0,  0,  1, 0, 0, 1, 0, 4}, // R4 second source bypass
        '{1, 1, 19, 15,  0, 0,  0,  1, 0, 0, 0, 0, 5}  // R5 after mul writeback
    };

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (issue,f0,u0,f1,u1)", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] p, input logic [4:0] d,
                         input logic [4:0] s0, input logic [4:0] s1,
                         input logic dv, input logic [4:0] dr);
        cand_valid = v; cand_pipe = p; cand_dst = d;
        cand_src0 = s0; cand_src1 = s1; done_valid = dv; done_reg = dr;
    endtask

    function automatic logic [6:0] outs();
        return {issue, src0_fwd, src0_unit, src1_fwd, src1_unit};
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1: watchdog expired, got running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i].v, VEC[i].p, VEC[i].d, VEC[i].s0, VEC[i].s1, VEC[i].dv, VEC[i].dr);
            #1;
            check($sformatf("R%0d vec %0d", VEC[i].rq, i), outs(),
                  {VEC[i].ei, VEC[i].f0, VEC[i].u0, VEC[i].f1, VEC[i].u1});
        end

        // R9: reset drops in-flight mul r20 and pending r21
        @(negedge clk);
        drive(1, 2'd2, 5'd20, 5'd0, 5'd0, 0, 5'd0);
        #1 check("R9 mul r20", outs(), 7'b1000000);
        @(negedge clk);
        drive(1, 2'd3, 5'd21, 5'd0, 5'd0, 0, 5'd0);
        #1 check("R9 var r21", outs(), 7'b1000000);
        @(negedge clk);
        drive(0, 2'd0, 5'd0, 5'd0, 5'd0, 0, 5'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1, 2'd0, 5'd22, 5'd20, 5'd21, 0, 5'd0);
        #1 check("R9 after reset", outs(), 7'b1000000);
        @(negedge clk);
        drive(0, 2'd0, 5'd0, 5'd0, 5'd0, 0, 5'd0);
        #1 check("R1 idle after reset", outs(), 7'b0000000);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule